// File: doc/BRIEF.md
# Display Controller Two-Wire Write Receiver

This block is the serial front end of a small display controller. It watches the two-wire bus (clock SCL, data SDA) by sampling both lines with the fast system clock. It finds start and stop conditions and frames the bits into bytes. It accepts write transfers addressed to the controller and drives the acknowledge slot for every byte it accepts.

The 7-bit device address is a fixed 6-bit prefix followed by one bit taken from a board strap. After the address, the master sends a control byte. Bit 7 of the control byte (continuation flag) says whether more control bytes will follow. Bit 6 (route flag) says whether the bytes that follow are commands or pixel data. Command bytes leave on a one-cycle strobe toward the command logic. Pixel bytes are written to a display RAM port at a column pointer. The pointer advances by itself after every write, and the command logic can load it.

Top module: `disp_i2c_wr_rx`

## Requirements
- R1: The address byte is accepted and acknowledged only when its upper seven bits equal `011110` followed by `sa0_i`, and bit 0 (read/write) is 0. With the defaults this is byte 0x78 when `sa0_i`=0 and byte 0x7A when `sa0_i`=1.
- R2: An address that does not match, or an address with bit 0 = 1, gets no acknowledge. Until the next start, the receiver then acknowledges nothing and produces no command strobe and no RAM write.
- R3: `sda_oe` is raised (pulling SDA low) only while SCL is low, after the 8th bit of an accepted address, control or payload byte. It is held through the 9th clock high phase and released after that clock falls. It is 0 at all other times.
- R4: The byte after an accepted address is a control byte. Its bit 7 is the continuation flag and its bit 6 is the route flag. Bits 5..0 are not used.
- R5: With route flag 0, each payload byte raises `cmd_valid` for exactly one clock with the byte on `cmd_byte`. `ram_we` stays low.
- R6: With route flag 1, each payload byte raises `ram_we` for one clock with the byte on `ram_wdata` and the current pointer on `ram_addr`. `cmd_valid` stays low.
- R7: After each RAM write, `ram_addr` advances by one. It wraps from 127 (COLS-1) to 0.
- R8: A one-cycle `col_load` sets `ram_addr` to `col_load_val` on the next clock. A load takes priority over an increment in the same cycle.
- R9: With continuation flag 0, every later byte until stop or start is payload, even one that looks like a control byte. With continuation flag 1, each payload byte is followed by a new control byte, so control and payload alternate.
- R10: A start or a stop resets the byte framing and releases `sda_oe`. A repeated start in the middle of a byte discards the partial byte, and the next byte is read as an address.
- R11: After reset, `sda_oe`, `cmd_valid` and `ram_we` are 0 and `ram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sa0_i | input | 1 | Strap that sets address bit 0 |
| col_load | input | 1 | Load strobe for the column pointer |
| col_load_val | input | 7 | Value loaded into the column pointer |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| cmd_valid | output | 1 | One-cycle command byte strobe |
| cmd_byte | output | 8 | Command byte, valid with cmd_valid |
| ram_we | output | 1 | One-cycle display RAM write enable |
| ram_addr | output | 7 | Column pointer, used as RAM write address |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
A wrong bit counter or a stale framing state shows at the ports within one byte time. A misplaced acknowledge is seen in the 9th clock slot, and a byte sent on the wrong route appears as a strobe on the wrong output. A control byte read as payload, or the reverse, changes the count and order of strobes in the alternating and streaming transfers. A pointer fault appears in the `ram_addr` of the very next write, including the write that follows address 127. The repeated start and stop cases show whether framing recovers on the first byte after the condition.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_ADDR,
      RX_CTRL,
      RX_PAYLOAD,
      RX_IGNORE
   } rx_state_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
   } bus_evt_t;

endpackage

// File: rtl/disp_i2c_sync.sv
module disp_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("disp_i2c_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/disp_i2c_cond.sv
module disp_i2c_cond
   import disp_i2c_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.start    = scl_q & scl_s & sda_q & ~sda_s;
      evt.stop     = scl_q & scl_s & ~sda_q & sda_s;
      evt.scl_rise = ~scl_q & scl_s;
      evt.scl_fall = scl_q & ~scl_s;
   end
endmodule

// File: rtl/disp_i2c_colptr.sv
module disp_i2c_colptr #(
   parameter int COLS  = 128,
   parameter int COL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [COL_W-1:0] load_val,
   output logic [COL_W-1:0] ptr
);
   logic [COL_W-1:0] ptr_q, ptr_nxt;

   if (COLS == (1 << COL_W)) begin : g_pow2_wrap
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_cmp_wrap
      assign ptr_nxt = (ptr_q == COL_W'(COLS - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr_q <= '0;
      else if (load) ptr_q <= load_val;
      else if (inc)  ptr_q <= ptr_nxt;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/disp_i2c_wr_rx.sv
module disp_i2c_wr_rx
   import disp_i2c_pkg::*;
#(
   parameter logic [5:0] ADDR_PREFIX = 6'b011110,
   parameter int         COLS        = 128,
   parameter int         SYNC_STAGES = 2,
   localparam int        COL_W       = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             sa0_i,
   input  logic             col_load,
   input  logic [COL_W-1:0] col_load_val,
   output logic             sda_oe,
   output logic             cmd_valid,
   output logic [7:0]       cmd_byte,
   output logic             ram_we,
   output logic [COL_W-1:0] ram_addr,
   output logic [7:0]       ram_wdata
);
   if (COLS < 2) begin : g_bad_cols
      $error("disp_i2c_wr_rx: COLS must be at least 2");
   end

   logic      scl_s, sda_s;
   bus_evt_t  evt;
   rx_state_t state;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic       co_q, dc_q, oe_q;
   logic       cmd_v_q, we_q;
   logic [7:0] cmd_q, wdat_q;
   logic       addr_hit;

   disp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   disp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   disp_i2c_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt));

   assign addr_hit = (shreg[7:1] == {ADDR_PREFIX, sa0_i}) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         co_q    <= 1'b0;
         dc_q    <= 1'b0;
         oe_q    <= 1'b0;
         cmd_v_q <= 1'b0;
         we_q    <= 1'b0;
         cmd_q   <= '0;
         wdat_q  <= '0;
      end else begin
         cmd_v_q <= 1'b0;
         we_q    <= 1'b0;
         if (evt.start) begin
            state  <= RX_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
         end else if (evt.stop) begin
            state  <= RX_IDLE;
            bitcnt <= '0;
            oe_q   <= 1'b0;
         end else if (state != RX_IDLE && state != RX_IGNORE) begin
            if (evt.scl_rise) begin
               if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end else if (evt.scl_fall) begin
               if (bitcnt == 4'd8) begin
                  unique case (state)
                     RX_ADDR: begin
                        if (addr_hit) begin
                           oe_q  <= 1'b1;
                           state <= RX_CTRL;
                        end else begin
                           state <= RX_IGNORE;
                        end
                     end
                     RX_CTRL: begin
                        co_q  <= shreg[7];
                        dc_q  <= shreg[6];
                        oe_q  <= 1'b1;
                        state <= RX_PAYLOAD;
                     end
                     RX_PAYLOAD: begin
                        oe_q <= 1'b1;
                        if (dc_q) begin
                           we_q   <= 1'b1;
                           wdat_q <= shreg;
                        end else begin
                           cmd_v_q <= 1'b1;
                           cmd_q   <= shreg;
                        end
                        if (co_q) state <= RX_CTRL;
                     end
                     default: state <= RX_IDLE;
                  endcase
               end else if (bitcnt == 4'd9) begin
                  oe_q   <= 1'b0;
                  bitcnt <= '0;
               end
            end
         end
      end
   end

   disp_i2c_colptr #(.COLS(COLS), .COL_W(COL_W)) u_colptr (
      .clk(clk), .rst_n(rst_n), .inc(we_q), .load(col_load),
      .load_val(col_load_val), .ptr(ram_addr));

   assign sda_oe    = oe_q;
   assign cmd_valid = cmd_v_q;
   assign cmd_byte  = cmd_q;
   assign ram_we    = we_q;
   assign ram_wdata = wdat_q;
endmodule

// File: rtl/disp_i2c_wr_rx_chk.sv
module disp_i2c_wr_rx_chk #(
   parameter int COLS  = 128,
   parameter int COL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_evt,
   input logic             stop_evt,
   input logic             sda_oe,
   input logic             cmd_valid,
   input logic             ram_we,
   input logic [COL_W-1:0] ram_addr,
   input logic             col_load,
   input logic [COL_W-1:0] col_load_val
);
   p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   p_route_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && ram_we));

   p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   p_col_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !col_load) |=>
      ram_addr == (($past(ram_addr) == COL_W'(COLS - 1)) ? '0 : $past(ram_addr) + 1'b1));

   p_col_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      col_load |=> ram_addr == $past(col_load_val));

   p_frame_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt || stop_evt) |=> !sda_oe);
endmodule

bind disp_i2c_wr_rx disp_i2c_wr_rx_chk #(.COLS(COLS), .COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
   .start_evt(evt.start), .stop_evt(evt.stop),
   .sda_oe(sda_oe), .cmd_valid(cmd_valid), .ram_we(ram_we),
   .ram_addr(ram_addr), .col_load(col_load), .col_load_val(col_load_val));

// File: tb/disp_i2c_wr_rx_tb_top.sv
module disp_i2c_wr_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sa0 = 1'b0;
   logic       col_load = 1'b0;
   logic [6:0] col_load_val = '0;
   logic       sda_oe, cmd_valid, ram_we;
   logic [7:0] cmd_byte, ram_wdata;
   logic [6:0] ram_addr;
   wire        sda_line = sda_m & ~sda_oe;

   int total = 0, bad = 0;
   bit done = 0;

   logic [7:0] cmd_log [64];
   logic [7:0] ram_dlog [64];
   logic [6:0] ram_alog [64];
   int cmd_n = 0, ram_n = 0;

   always #2 clk = ~clk;

   disp_i2c_wr_rx dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sa0_i(sa0),
      .col_load(col_load), .col_load_val(col_load_val), .sda_oe(sda_oe),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata));

   always @(posedge clk) begin
      if (rst_n) begin
         if (cmd_valid) begin cmd_log[cmd_n % 64] = cmd_byte; cmd_n++; end
         if (ram_we) begin
            ram_dlog[ram_n % 64] = ram_wdata;
            ram_alog[ram_n % 64] = ram_addr;
            ram_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; hc(4);
      scl_m = 1'b1; hc(8);
      sda_m = 1'b0; hc(8);
      scl_m = 1'b0; hc(4);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; hc(4);
      scl_m = 1'b1; hc(8);
      sda_m = 1'b1; hc(8);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; hc(4);
      scl_m = 1'b1; hc(8);
      scl_m = 1'b0; hc(4);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; hc(4);
      scl_m = 1'b1; hc(4);
      ack = sda_oe;
      hc(4);
      scl_m = 1'b0; hc(4);
   endtask

   task automatic t_reset();
      chk(sda_oe == 0, "R11 sda_oe", sda_oe, 0);
      chk(cmd_valid == 0 && ram_we == 0, "R11 strobes", {cmd_valid, ram_we}, 0);
      chk(ram_addr == 0, "R11 ram_addr", ram_addr, 0);
   endtask

   task automatic t_cmd_stream();
      bit a;
      int c0 = cmd_n, r0 = ram_n;
      logic [7:0] bytes [3] = '{8'hAE, 8'hD5, 8'h80};
      i2c_start();
      send_byte(8'h78, a); chk(a, "R1 addr ack", a, 1);
      send_byte(8'h00, a); chk(a, "R3 ctrl ack", a, 1);
      for (int i = 0; i < 3; i++) begin
         send_byte(bytes[i], a); chk(a, "R3 payload ack", a, 1);
      end
      i2c_stop(); hc(4);
      chk(cmd_n - c0 == 3, "R5 cmd count", cmd_n - c0, 3);
      chk(ram_n == r0, "R5 no ram write", ram_n - r0, 0);
      for (int i = 0; i < 3; i++)
         chk(cmd_log[(c0 + i) % 64] == bytes[i], "R9 r5_ cmd byte", cmd_log[(c0 + i) % 64], bytes[i]);
      chk(sda_oe == 0, "R3 released", sda_oe, 0);
   endtask

   task automatic t_data_stream();
      bit a;
      int c0 = cmd_n, r0 = ram_n;
      logic [7:0] bytes [3] = '{8'h11, 8'h80, 8'hC0};
      i2c_start();
      send_byte(8'h78, a);
      send_byte(8'h40, a); chk(a, "R4 ctrl ack", a, 1);
      for (int i = 0; i < 3; i++) send_byte(bytes[i], a);
      i2c_stop(); hc(4);
      chk(ram_n - r0 == 3, "R9 Co=0 all payload", ram_n - r0, 3);
      chk(cmd_n == c0, "R6 no cmd", cmd_n - c0, 0);
      for (int i = 0; i < 3; i++) begin
         chk(ram_dlog[(r0 + i) % 64] == bytes[i], "R6 wdata", ram_dlog[(r0 + i) % 64], bytes[i]);
         chk(ram_alog[(r0 + i) % 64] == 7'(i), "R7 addr step", ram_alog[(r0 + i) % 64], i);
      end
      chk(ram_addr == 3, "R7 pointer after", ram_addr, 3);
   endtask

   task automatic t_wrap();
      bit a;
      int r0;
      logic [6:0] exp_a [3] = '{7'd126, 7'd127, 7'd0};
      @(negedge clk); col_load = 1'b1; col_load_val = 7'd126;
      @(negedge clk); col_load = 1'b0;
      chk(ram_addr == 126, "R8 load", ram_addr, 126);
      r0 = ram_n;
      i2c_start();
      send_byte(8'h78, a);
      send_byte(8'h40, a);
      send_byte(8'hAA, a); send_byte(8'hBB, a); send_byte(8'hCC, a);
      i2c_stop(); hc(4);
      for (int i = 0; i < 3; i++)
         chk(ram_alog[(r0 + i) % 64] == exp_a[i], "R7 wrap", ram_alog[(r0 + i) % 64], exp_a[i]);
      chk(ram_addr == 1, "R7 after wrap", ram_addr, 1);
   endtask

   task automatic t_alternate();
      bit a;
      int c0 = cmd_n, r0 = ram_n;
      i2c_start();
      send_byte(8'h78, a);
      send_byte(8'h80, a); send_byte(8'h21, a);
      send_byte(8'hC0, a); chk(a, "R9 second ctrl ack", a, 1);
      send_byte(8'h55, a);
      send_byte(8'h80, a); send_byte(8'h22, a);
      i2c_stop(); hc(4);
      chk(cmd_n - c0 == 2, "R9 alt cmd count", cmd_n - c0, 2);
      chk(cmd_log[c0 % 64] == 8'h21 && cmd_log[(c0 + 1) % 64] == 8'h22, "R4 alt cmds",
          {cmd_log[c0 % 64], cmd_log[(c0 + 1) % 64]}, 16'h2122);
      chk(ram_n - r0 == 1, "R9 alt ram count", ram_n - r0, 1);
      chk(ram_dlog[r0 % 64] == 8'h55 && ram_alog[r0 % 64] == 1, "R6 alt write",
          {ram_alog[r0 % 64], ram_dlog[r0 % 64]}, {7'd1, 8'h55});
   endtask

   task automatic t_bad_addr();
      bit a;
      int c0 = cmd_n, r0 = ram_n;
      sa0 = 1'b0;
      i2c_start();
      send_byte(8'h7A, a); chk(!a, "R2 wrong sa0 nack", a, 0);
      send_byte(8'h00, a); chk(!a, "R2 ignored ctrl", a, 0);
      send_byte(8'h11, a); chk(!a, "R2 ignored byte", a, 0);
      i2c_stop();
      i2c_start();
      send_byte(8'h79, a); chk(!a, "R2 read nack", a, 0);
      send_byte(8'h40, a); send_byte(8'h33, a);
      i2c_stop(); hc(4);
      chk(cmd_n == c0 && ram_n == r0, "R2 no output", cmd_n - c0 + ram_n - r0, 0);
      sa0 = 1'b1; hc(4);
      i2c_start();
      send_byte(8'h7A, a); chk(a, "R1 strap sa0=1 ack", a, 1);
      i2c_stop();
      i2c_start();
      send_byte(8'h78, a); chk(!a, "R1 strap sa0=1 rejects 0x78", a, 0);
      i2c_stop();
      sa0 = 1'b0; hc(4);
   endtask

   task automatic t_restart();
      bit a;
      int c0 = cmd_n;
      i2c_start();
      send_byte(8'h78, a);
      send_byte(8'h00, a);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      i2c_start();
      send_byte(8'h78, a); chk(a, "R10 addr after restart", a, 1);
      send_byte(8'h00, a);
      send_byte(8'hA5, a);
      i2c_stop(); hc(4);
      chk(cmd_n - c0 == 1, "R10 cmd count", cmd_n - c0, 1);
      chk(cmd_log[c0 % 64] == 8'hA5, "R10 cmd value", cmd_log[c0 % 64], 8'hA5);
      chk(sda_oe == 0, "R10 released", sda_oe, 0);
   endtask

   initial begin
      hc(5); rst_n = 1'b1; hc(5);
      t_reset();
      t_cmd_stream();
      t_data_stream();
      t_wrap();
      t_alternate();
      t_bad_addr();
      t_restart();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule